// File: doc/BRIEF.md
# Dual-Channel Converter Readout Sequencer

This block runs a two-channel sampling converter from the host side. The two channels share one 14-bit tri-state data bus. The block makes the start-convert pulse for each channel. In shared mode one pulse train drives both channels. In independent mode each channel runs at its own rate. A rising edge on a channel's end-of-conversion line, after synchronisation, marks that channel's result as waiting. A single reader then pulls the waiting results off the shared bus, one channel at a time.

For each read, the reader drives that channel's active-low output enable. It waits a programmed settling time before it captures the bus. It then releases the enable and holds both enables high for a programmed turnaround before the next read. The captured offset-binary code becomes a sign-extended two's-complement value on a valid/ready stream, tagged with the channel it came from. Every timing value is a count of system clocks. Each one is raised to a built-in floor before use. Two sticky flags report trouble: a result dropped because the stream was still full, and an end-of-conversion that never came.

Top module: `dual_adc_seq`

## Requirements
- R1: While reset is held and before `run` is raised, both start outputs are 0, both enables are 1, `m_valid` is 0, and `overrun` and `timeout_err` are 0.
- R2: With `run` high, a start output is high for hi = max(`cfg_hi`, MIN_HI) cycles and repeats every max(`cfg_period`, MIN_PERIOD, hi + max(`cfg_lo`, MIN_LO)) cycles. The defaults are MIN_HI=3, MIN_LO=3 and MIN_PERIOD=10.
- R3: With `cfg_shared`=1, `conv_start_b` equals `conv_start_a` in every cycle, and both follow `cfg_period_a`. With `cfg_shared`=0, channel B follows `cfg_period_b` on its own.
- R4: The two enables are never low together. Between one enable going high and the next going low, both stay high for at least max(`cfg_turn`, MIN_TURN) cycles (MIN_TURN=2).
- R5: Each read holds one enable low for exactly max(`cfg_en`, MIN_EN) cycles (MIN_EN=2) and captures the bus at the end of that window. Output `m_data` is code minus 8192 as a 16-bit two's-complement value, so code 0 gives 0xE000, 0x2000 gives 0 and 0x3FFF gives 0x1FFF. `m_chan` is 0 for channel A and 1 for channel B.
- R6: When both channels have results waiting, channel A is read first.
- R7: `m_valid` with its data stays stable until `m_ready`. A result captured while an unaccepted sample is still held is dropped, and `overrun` is set and stays set. The start cadence does not change while the stream is stalled.
- R8: If no end-of-conversion rising edge is seen within max(`cfg_tmo`, MIN_TMO) cycles of a start rising edge (MIN_TMO=8), `timeout_err` is set and stays set. Normal conversions never set it.
- R9: The end-of-conversion inputs pass through a two-flop synchroniser. Each rising edge yields exactly one read, so every conversion is delivered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables start-pulse generation |
| cfg_shared | input | 1 | 1: one pulse train for both channels |
| cfg_hi | input | 12 | Start pulse high time, cycles |
| cfg_lo | input | 12 | Minimum start pulse low time, cycles |
| cfg_period_a | input | 12 | Channel A (and shared) start period, cycles |
| cfg_period_b | input | 12 | Channel B start period in independent mode |
| cfg_en | input | 12 | Enable-to-capture wait, cycles |
| cfg_turn | input | 12 | Bus release turnaround, cycles |
| cfg_tmo | input | 12 | End-of-conversion timeout window, cycles |
| conv_start_a | output | 1 | Start-convert pulse, channel A |
| conv_start_b | output | 1 | Start-convert pulse, channel B |
| eoc_a | input | 1 | End-of-conversion, channel A (asynchronous) |
| eoc_b | input | 1 | End-of-conversion, channel B (asynchronous) |
| oe_a_n | output | 1 | Active-low output enable, channel A |
| oe_b_n | output | 1 | Active-low output enable, channel B |
| bus_d | input | 14 | Shared converter data bus, offset binary |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 16 | Two's-complement sample |
| m_chan | output | 1 | Channel tag, 0=A 1=B |
| overrun | output | 1 | Sticky: a sample was dropped |
| timeout_err | output | 1 | Sticky: end-of-conversion missing |

## Verification
A start output changes on the clock edge after the counter reaches its boundary, so pulse widths and periods are counted at falling clock edges from one observed rising edge to the next. A result reaches the stream about four cycles plus the enable wait after its end-of-conversion edge: two synchroniser flops, the pending flag, the arbiter issue and then the capture edge. Because that delay shifts with arbitration, the scoreboard matches results by order per channel and never by a fixed cycle. The enable low time and the turnaround gap are counted at falling edges and compared exactly with the clamped settings. The overrun and timeout flags are read only after the bench has left enough quiet cycles for them to settle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ENA  = 2'd1,
    RD_TURN = 2'd2
  } rd_state_t;
endpackage

// File: rtl/adc_start_gen.sv
module adc_start_gen #(
  parameter int CW      = 12,
  parameter int MIN_HI  = 3,
  parameter int MIN_LO  = 3,
  parameter int MIN_PER = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cfg_hi,
  input  logic [CW-1:0] cfg_lo,
  input  logic [CW-1:0] cfg_per,
  output logic          start_o,
  output logic          due_o
);
  logic [CW:0] hi_eff, lo_eff, sum_eff, per_eff;
  logic [CW:0] cnt_q, cnt_d;
  logic        start_d, due_d;
  logic [CW:0] hi_len;

  always_comb begin
    hi_eff = (cfg_hi < CW'(MIN_HI)) ? (CW+1)'(MIN_HI) : {1'b0, cfg_hi};
    lo_eff = (cfg_lo < CW'(MIN_LO)) ? (CW+1)'(MIN_LO) : {1'b0, cfg_lo};
    sum_eff = hi_eff + lo_eff;
    per_eff = (cfg_per < CW'(MIN_PER)) ? (CW+1)'(MIN_PER) : {1'b0, cfg_per};
    if (per_eff < sum_eff) per_eff = sum_eff;
  end

  always_comb begin
    cnt_d   = '0;
    start_d = 1'b0;
    due_d   = 1'b0;
    if (run) begin
      cnt_d   = (cnt_q >= per_eff - 1'b1) ? '0 : cnt_q + 1'b1;
      start_d = (cnt_q < hi_eff);
      due_d   = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
      due_o   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      start_o <= start_d;
      due_o   <= due_d;
    end
  end

  // checker counter: length of the current high phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else        hi_len <= start_o ? hi_len + 1'b1 : '0;
  end

  // R2: a pulse ended by the counter lasted at least the floor
  a_r2_hi_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_o) && $past(run)) |-> (hi_len >= (CW+1)'(MIN_HI)));
endmodule

// File: rtl/adc_eoc_watch.sv
module adc_eoc_watch #(
  parameter int CW      = 12,
  parameter int MIN_TMO = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoc_async,
  input  logic          arm,
  input  logic [CW-1:0] cfg_tmo,
  output logic          done_o,
  output logic          tmo_o
);
  logic          s1_q, s2_q, s3_q;
  logic          armed_q, armed_d, hit_d;
  logic [CW-1:0] tcnt_q, tcnt_d, tmo_eff;

  assign tmo_eff = (cfg_tmo < CW'(MIN_TMO)) ? CW'(MIN_TMO) : cfg_tmo;
  assign done_o  = s2_q & ~s3_q;

  always_comb begin
    armed_d = armed_q;
    tcnt_d  = tcnt_q;
    hit_d   = 1'b0;
    if (arm) begin
      armed_d = 1'b1;
      tcnt_d  = '0;
    end else if (done_o) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (tcnt_q == tmo_eff - 1'b1) begin
        hit_d   = 1'b1;
        armed_d = 1'b0;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      armed_q <= 1'b0;
      tcnt_q  <= '0;
      tmo_o   <= 1'b0;
    end else begin
      s1_q    <= eoc_async;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      armed_q <= armed_d;
      tcnt_q  <= tcnt_d;
      tmo_o   <= hit_d;
    end
  end

  // R8: a timeout hit only comes from an armed, still-waiting window
  a_r8_hit_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> $past(armed_q));
endmodule

// File: rtl/adc_bus_reader.sv
module adc_bus_reader
  import adc_seq_pkg::*;
#(
  parameter int W        = 14,
  parameter int OW       = 16,
  parameter int CW       = 12,
  parameter int MIN_EN   = 2,
  parameter int MIN_TURN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_a,
  input  logic          done_b,
  input  logic [CW-1:0] cfg_en,
  input  logic [CW-1:0] cfg_turn,
  input  logic [W-1:0]  bus_d,
  output logic          oe_a_n,
  output logic          oe_b_n,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_data,
  output logic          m_chan,
  output logic          overrun
);
  rd_state_t     st_q, st_d;
  logic          sel_q, sel_d, pa_q, pa_d, pb_q, pb_d;
  logic          oa_d, ob_d, cap;
  logic [CW-1:0] cnt_q, cnt_d, en_eff, turn_eff;
  logic          mv_d, mc_d, ov_d;
  logic [OW-1:0] md_d, conv;

  assign en_eff   = (cfg_en < CW'(MIN_EN)) ? CW'(MIN_EN) : cfg_en;
  assign turn_eff = (cfg_turn < CW'(MIN_TURN)) ? CW'(MIN_TURN) : cfg_turn;
  assign conv     = {{(OW-W+1){~bus_d[W-1]}}, bus_d[W-2:0]};

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    cnt_d = cnt_q;
    pa_d  = pa_q | done_a;
    pb_d  = pb_q | done_b;
    oa_d  = oe_a_n;
    ob_d  = oe_b_n;
    cap   = 1'b0;
    unique case (st_q)
      RD_IDLE: begin
        if (pa_q) begin
          sel_d = 1'b0; oa_d = 1'b0; pa_d = done_a;
          cnt_d = '0;   st_d = RD_ENA;
        end else if (pb_q) begin
          sel_d = 1'b1; ob_d = 1'b0; pb_d = done_b;
          cnt_d = '0;   st_d = RD_ENA;
        end
      end
      RD_ENA: begin
        if (cnt_q == en_eff - 1'b1) begin
          cap  = 1'b1;  oa_d = 1'b1; ob_d = 1'b1;
          cnt_d = '0;   st_d = RD_TURN;
        end else cnt_d = cnt_q + 1'b1;
      end
      RD_TURN: begin
        if (cnt_q == turn_eff - 1'b1) st_d = RD_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_comb begin
    mv_d = m_valid;
    md_d = m_data;
    mc_d = m_chan;
    ov_d = overrun;
    if (cap) begin
      if (m_valid && !m_ready) ov_d = 1'b1;
      else begin
        mv_d = 1'b1; md_d = conv; mc_d = sel_q;
      end
    end else if (m_ready) mv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RD_IDLE; sel_q <= 1'b0; cnt_q <= '0;
      pa_q <= 1'b0;    pb_q <= 1'b0;
      oe_a_n <= 1'b1;  oe_b_n <= 1'b1;
      m_valid <= 1'b0; m_data <= '0; m_chan <= 1'b0; overrun <= 1'b0;
    end else begin
      st_q <= st_d; sel_q <= sel_d; cnt_q <= cnt_d;
      pa_q <= pa_d; pb_q <= pb_d;
      oe_a_n <= oa_d; oe_b_n <= ob_d;
      m_valid <= mv_d; m_data <= md_d; m_chan <= mc_d; overrun <= ov_d;
    end
  end

  // R4: never both channels driving the shared bus
  a_r4_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n));
  // R5: a new sample only appears right after an enable window
  a_r5_capture_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(!oe_a_n || !oe_b_n));
  // R7: stalled sample holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));
  // R7: overrun is sticky
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq #(
  parameter int W          = 14,
  parameter int OW         = 16,
  parameter int CW         = 12,
  parameter int MIN_HI     = 3,
  parameter int MIN_LO     = 3,
  parameter int MIN_PERIOD = 10,
  parameter int MIN_EN     = 2,
  parameter int MIN_TURN   = 2,
  parameter int MIN_TMO    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_shared,
  input  logic [CW-1:0] cfg_hi,
  input  logic [CW-1:0] cfg_lo,
  input  logic [CW-1:0] cfg_period_a,
  input  logic [CW-1:0] cfg_period_b,
  input  logic [CW-1:0] cfg_en,
  input  logic [CW-1:0] cfg_turn,
  input  logic [CW-1:0] cfg_tmo,
  output logic          conv_start_a,
  output logic          conv_start_b,
  input  logic          eoc_a,
  input  logic          eoc_b,
  output logic          oe_a_n,
  output logic          oe_b_n,
  input  logic [W-1:0]  bus_d,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_data,
  output logic          m_chan,
  output logic          overrun,
  output logic          timeout_err
);
  localparam int NCH = 2;

  logic [CW-1:0] per [NCH];
  logic [NCH-1:0] gen_run, gen_start, gen_due, arm, eoc_in, done, tmo_hit;

  assign per[0]     = cfg_period_a;
  assign per[1]     = cfg_period_b;
  assign gen_run[0] = run;
  assign gen_run[1] = run & ~cfg_shared;
  assign eoc_in     = {eoc_b, eoc_a};

  assign conv_start_a = gen_start[0];
  assign conv_start_b = cfg_shared ? gen_start[0] : gen_start[1];
  assign arm[0]       = gen_due[0];
  assign arm[1]       = cfg_shared ? gen_due[0] : gen_due[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    adc_start_gen #(.CW(CW), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO), .MIN_PER(MIN_PERIOD)) u_gen (
      .clk(clk), .rst_n(rst_n), .run(gen_run[c]), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
      .cfg_per(per[c]), .start_o(gen_start[c]), .due_o(gen_due[c]));
    adc_eoc_watch #(.CW(CW), .MIN_TMO(MIN_TMO)) u_watch (
      .clk(clk), .rst_n(rst_n), .eoc_async(eoc_in[c]), .arm(arm[c]),
      .cfg_tmo(cfg_tmo), .done_o(done[c]), .tmo_o(tmo_hit[c]));
  end

  adc_bus_reader #(.W(W), .OW(OW), .CW(CW), .MIN_EN(MIN_EN), .MIN_TURN(MIN_TURN)) u_rd (
    .clk(clk), .rst_n(rst_n), .done_a(done[0]), .done_b(done[1]),
    .cfg_en(cfg_en), .cfg_turn(cfg_turn), .bus_d(bus_d),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_chan(m_chan), .overrun(overrun));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeout_err <= 1'b0;
    else if (|tmo_hit) timeout_err <= 1'b1;
  end

  // R8: timeout flag is sticky
  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  // R3: in shared mode both start lines match
  a_r3_shared_same: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shared |-> (conv_start_a == conv_start_b));
endmodule

// File: tb/dual_adc_seq_tb_top.sv
module dual_adc_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, run, cfg_shared, eoc_a, eoc_b, m_ready;
  logic [11:0] cfg_hi, cfg_lo, cfg_period_a, cfg_period_b, cfg_en, cfg_turn, cfg_tmo;
  logic conv_start_a, conv_start_b, oe_a_n, oe_b_n, m_valid, m_chan, overrun, timeout_err;
  logic [15:0] m_data;
  logic [13:0] dat_a, dat_b;
  wire  [13:0] bus = (!oe_a_n) ? dat_a : ((!oe_b_n) ? dat_b : 14'bz);

  int n_chk = 0, n_fail = 0;
  int na = 0, nb = 0;
  logic [15:0] qa[$], qb[$];
  bit mon_en = 0, first_seen = 0, mute_b = 0, rdy_en = 0;
  int exp_en = 3, exp_turn = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_shared(cfg_shared),
    .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_period_a(cfg_period_a), .cfg_period_b(cfg_period_b),
    .cfg_en(cfg_en), .cfg_turn(cfg_turn), .cfg_tmo(cfg_tmo),
    .conv_start_a(conv_start_a), .conv_start_b(conv_start_b),
    .eoc_a(eoc_a), .eoc_b(eoc_b), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_d(bus),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
    .overrun(overrun), .timeout_err(timeout_err));

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [13:0] code_for(input int ch, input int n);
    case (n)
      0: return ch ? 14'h3FFF : 14'h0000;
      1: return 14'h2000;
      2: return ch ? 14'h0000 : 14'h3FFF;
      3: return 14'h1FFF;
      default: return 14'((n * 4951 + ch * 777 + 2748) & 16383);
    endcase
  endfunction

  function automatic logic [15:0] to_signed(input logic [13:0] c);
    int s;
    s = int'(c) - 8192;
    return s[15:0];
  endfunction

  // converter stub: result valid 8 ns after the start edge, flag drops with start
  always begin
    @(posedge conv_start_a);
    #8;
    dat_a = code_for(0, na); na++;
    qa.push_back(to_signed(dat_a));
    eoc_a = 1'b1;
  end
  always begin
    @(negedge conv_start_a);
    eoc_a = 1'b0;
  end
  always begin
    @(posedge conv_start_b);
    #8;
    if (!mute_b) begin
      dat_b = code_for(1, nb); nb++;
      qb.push_back(to_signed(dat_b));
      eoc_b = 1'b1;
    end
  end
  always begin
    @(negedge conv_start_b);
    eoc_b = 1'b0;
  end

  // ready driver, changes 1 ns after the rising edge
  int rcyc = 0;
  always begin
    @(posedge clk);
    #1;
    rcyc++;
    m_ready = rdy_en && ((rcyc % 3) != 0);
  end

  // scoreboard monitor (R5, R6, R9)
  always @(negedge clk) begin
    if (mon_en && m_valid && m_ready) begin
      if (!first_seen) begin
        first_seen = 1;
        check(m_chan == 1'b0, "R6", "first channel after joint finish", int'(m_chan), 0);
      end
      if (m_chan == 1'b0) begin
        if (qa.size() == 0) check(0, "R9", "unexpected A sample", int'(m_data), -1);
        else begin
          check(m_data == qa[0], "R5", "A sample value", int'(m_data), int'(qa[0]));
          void'(qa.pop_front());
        end
      end else begin
        if (qb.size() == 0) check(0, "R9", "unexpected B sample", int'(m_data), -1);
        else begin
          check(m_data == qb[0], "R5", "B sample value", int'(m_data), int'(qb[0]));
          void'(qb.pop_front());
        end
      end
    end
  end

  // enable window and turnaround monitor (R4, R5)
  int lowa = 0, lowb = 0, hcnt = 0;
  bit seen = 0, prev_both = 1;
  always @(negedge clk) begin
    if (!mon_en) begin
      lowa = 0; lowb = 0; hcnt = 0; seen = 0; prev_both = oe_a_n && oe_b_n;
    end else begin
      if (!oe_a_n) lowa++;
      else if (lowa > 0) begin
        check(lowa == exp_en, "R5", "A enable low cycles", lowa, exp_en); lowa = 0;
      end
      if (!oe_b_n) lowb++;
      else if (lowb > 0) begin
        check(lowb == exp_en, "R5", "B enable low cycles", lowb, exp_en); lowb = 0;
      end
      if (oe_a_n && oe_b_n) hcnt++;
      else if (prev_both) begin
        check(oe_a_n || oe_b_n, "R4", "both enables low", 1, 0);
        if (seen) check(hcnt >= exp_turn, "R4", "turnaround cycles", hcnt, exp_turn);
        seen = 1; hcnt = 0;
      end
      prev_both = oe_a_n && oe_b_n;
    end
  end

  task automatic measure(input bit ch, output int h, output int p, output int mism);
    int l;
    h = 0; l = 0; mism = 0;
    if (ch) @(posedge conv_start_b); else @(posedge conv_start_a);
    @(negedge clk);
    while ((ch ? conv_start_b : conv_start_a) == 1'b1) begin
      h++; if (conv_start_a != conv_start_b) mism++; @(negedge clk);
    end
    while ((ch ? conv_start_b : conv_start_a) == 1'b0) begin
      l++; if (conv_start_a != conv_start_b) mism++; @(negedge clk);
    end
    p = h + l;
  endtask

  task automatic quiet_flush();
    run = 0;
    repeat (80) @(negedge clk);
    qa.delete(); qb.delete();
    na = 0; nb = 0; first_seen = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int h, p, mm;
    bit diff;
    rst_n = 0; run = 0; cfg_shared = 1; eoc_a = 0; eoc_b = 0; m_ready = 0;
    dat_a = '0; dat_b = '0;
    cfg_hi = 1; cfg_lo = 8; cfg_period_a = 2; cfg_period_b = 2;
    cfg_en = 0; cfg_turn = 0; cfg_tmo = 0;
    repeat (4) @(negedge clk);
    check(!conv_start_a && !conv_start_b, "R1", "starts in reset", int'(conv_start_a), 0);
    check(oe_a_n && oe_b_n, "R1", "enables in reset", int'({oe_a_n, oe_b_n}), 3);
    check(!m_valid && !overrun && !timeout_err, "R1", "valid/flags in reset",
          int'({m_valid, overrun, timeout_err}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!conv_start_a && oe_a_n && oe_b_n && !m_valid, "R1", "idle after reset", int'(conv_start_a), 0);

    // clamp phase: hi 1->3, period max(2,10,3+8)=11
    rdy_en = 1;
    run = 1;
    measure(0, h, p, mm);
    check(h == 3, "R2", "clamped high width", h, 3);
    check(p == 11, "R2", "clamped period", p, 11);
    check(mm == 0, "R3", "shared start mismatch cycles", mm, 0);
    quiet_flush();

    // shared phase
    cfg_hi = 5; cfg_lo = 5; cfg_period_a = 60; cfg_en = 3; cfg_turn = 4; cfg_tmo = 200;
    exp_en = 3; exp_turn = 4;
    mon_en = 1;
    run = 1;
    measure(0, h, p, mm);
    check(h == 5, "R2", "high width", h, 5);
    check(p == 60, "R2", "period", p, 60);
    check(mm == 0, "R3", "shared start mismatch cycles", mm, 0);
    repeat (700) @(negedge clk);
    run = 0;
    repeat (80) @(negedge clk);
    check(qa.size() == 0 && qb.size() == 0, "R9", "undelivered samples", qa.size() + qb.size(), 0);

    // independent phase
    mon_en = 0; quiet_flush(); mon_en = 1; first_seen = 1;
    cfg_shared = 0; cfg_period_a = 47; cfg_period_b = 71;
    run = 1;
    measure(0, h, p, mm);
    check(p == 47, "R3", "A own period", p, 47);
    measure(1, h, p, mm);
    check(p == 71, "R3", "B own period", p, 71);
    diff = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (conv_start_a != conv_start_b) diff = 1;
    end
    check(diff, "R3", "independent starts differ", int'(diff), 1);
    repeat (1000) @(negedge clk);
    run = 0;
    repeat (80) @(negedge clk);
    check(qa.size() == 0 && qb.size() == 0, "R9", "undelivered samples", qa.size() + qb.size(), 0);
    check(!overrun, "R7", "no overrun with ready", int'(overrun), 0);
    check(!timeout_err, "R8", "no timeout in normal runs", int'(timeout_err), 0);

    // overrun phase
    mon_en = 0; quiet_flush();
    cfg_shared = 1; cfg_period_a = 60; rdy_en = 0;
    repeat (3) @(negedge clk);
    run = 1;
    measure(0, h, p, mm);
    check(p == 60, "R7", "period while stalled", p, 60);
    repeat (200) @(negedge clk);
    run = 0;
    repeat (40) @(negedge clk);
    check(m_valid == 1'b1, "R7", "held valid", int'(m_valid), 1);
    check(m_chan == 1'b0 && m_data == qa[0], "R7", "held first sample", int'(m_data), int'(qa[0]));
    check(overrun == 1'b1, "R7", "overrun set", int'(overrun), 1);
    rdy_en = 1;
    repeat (20) @(negedge clk);
    check(overrun == 1'b1, "R7", "overrun sticky", int'(overrun), 1);

    // timeout phase
    quiet_flush();
    mute_b = 1; cfg_shared = 0; cfg_period_a = 60; cfg_period_b = 60; cfg_tmo = 20;
    run = 1;
    repeat (150) @(negedge clk);
    check(timeout_err == 1'b1, "R8", "missing end of conversion", int'(timeout_err), 1);
    run = 0;
    repeat (20) @(negedge clk);
    check(timeout_err == 1'b1, "R8", "timeout sticky", int'(timeout_err), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule